// File: doc/BRIEF.md
# RX-Format Word Store Unit

This block carries out a 32-bit word store that is encoded as a four-byte register/index/base/displacement instruction. When an instruction word is presented, the block recognises the store opcode and splits the word into its register numbers and displacement. It then reads the source, index and base registers from an internal file of sixteen 32-bit general registers and adds base, index and displacement to form an effective address.

Before anything is written, the effective address goes through three checks: it must fall inside the memory, it must be word-aligned, and the per-block storage key must match the access key. If the address passes all three, the full source word is written big-endian into a byte-addressed memory model. If it fails, one fault code is reported and memory is left alone. Each accepted store produces exactly one outcome, a write strobe or a fault code, together with a one-cycle completion pulse.

Test access covers four things: loading registers, programming storage keys, setting the condition code, and reading back memory and registers. These ports are how the surrounding datapath, or a bench, prepares state and observes results.

Top module: `rx_store_unit`

## Requirements
- R1: An instruction is executed only when `instr_valid` is high and bits [31:24] of `instr_word` equal hex 50. Any other opcode produces no completion pulse, no write and no fault.
- R2: Field positions are fixed. Source register number is bits [23:20], index register number is bits [19:16], base register number is bits [15:12], and the unsigned displacement is bits [11:0].
- R3: The effective address includes the base register contents plus the zero-extended displacement (0 to 4095). A base field of 0 contributes zero.
- R4: An index field of 0 contributes zero. Otherwise the index register contents are added. The whole sum wraps modulo 2^32.
- R5: On a write, the full 32-bit source register value is stored big-endian: the byte at the effective address holds bits [31:24] and the byte at address+3 holds bits [7:0]. The source register keeps its value.
- R6: An effective address with bits [1:0] not zero gives fault code 2 (alignment), and no write occurs.
- R7: An effective address at or above `MEM_BYTES` gives fault code 1 (range), and no write occurs.
- R8: Storage keys are 4 bits, one per 2048-byte block (block = address bits [12:11] by default). A write proceeds only when the block key equals the access key, or when the access key is 0. Otherwise fault code 3 (protection) is given and memory is unchanged.
- R9: When several faults apply, only one is reported. Range takes priority over alignment, and alignment takes priority over protection. Code 0 means no fault.
- R10: `done` is high for exactly the one cycle that starts two rising edges after the instruction is sampled. In that cycle, either `wr_strobe` is high or `fault_code` is non-zero, never both. Neither is active without `done`.
- R11: `cc_out` resets to 0, changes only when loaded through `cc_set_valid`, and is never changed by a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Four-byte instruction |
| access_key | input | 4 | Access key for this instruction |
| gpr_we | input | 1 | General register write enable |
| gpr_waddr | input | 4 | General register write number |
| gpr_wdata | input | 32 | General register write data |
| gpr_raddr | input | 4 | General register read-back number |
| gpr_rdata | output | 32 | General register read-back data |
| key_we | input | 1 | Storage key table write enable |
| key_blk | input | KEY_IDX_W | Storage key block number |
| key_wdata | input | 4 | Storage key value |
| cc_set_valid | input | 1 | Load condition code |
| cc_set_value | input | 2 | Condition code value to load |
| cc_out | output | 2 | Current condition code |
| mem_raddr | input | MEM_AW | Memory read-back byte address |
| mem_rword | output | 32 | Word containing that byte address |
| mem_rbyte | output | 8 | Byte at that address |
| done | output | 1 | Completion pulse |
| wr_strobe | output | 1 | A word write took place |
| wr_addr | output | 32 | Address of the write |
| wr_data | output | 32 | Data of the write |
| fault_code | output | 2 | 0 none, 1 range, 2 alignment, 3 protection |

## Verification
Two functions can coincide on one effective address. Range, alignment and protection checks can all fail together, and a fault can collide with a write attempt that would otherwise have updated memory. The bench builds addresses that fail several checks at once: for example, 0x2001 is both out of range and misaligned, and 0x801 is both misaligned and in a foreign-key block. It compares the single reported code with the priority order. It also aims faulting stores at words that an earlier good store has filled, then reads those words back to confirm that no byte moved.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam logic [7:0] OPC_STORE_WORD = 8'h50;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_RANGE = 2'd1,
    FLT_ALIGN = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  typedef struct packed {
    logic [7:0]  opc;
    logic [3:0]  src;
    logic [3:0]  idx;
    logic [3:0]  base;
    logic [11:0] disp;
  } rx_fields_t;
endpackage

// File: rtl/rxs_gpr_file.sv
module rxs_gpr_file #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] ra_src,
  input  logic [$clog2(NREG)-1:0] ra_idx,
  input  logic [$clog2(NREG)-1:0] ra_base,
  input  logic [$clog2(NREG)-1:0] ra_dbg,
  output logic [DW-1:0]           rd_src,
  output logic [DW-1:0]           rd_idx,
  output logic [DW-1:0]           rd_base,
  output logic [DW-1:0]           rd_dbg
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rd_src  = regs_q[ra_src];
  assign rd_idx  = regs_q[ra_idx];
  assign rd_base = regs_q[ra_base];
  assign rd_dbg  = regs_q[ra_dbg];
endmodule

// File: rtl/rxs_agen.sv
module rxs_agen
  import rxs_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [31:0]   instr_word,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] idx_val,
  output logic [3:0]    src_num,
  output logic [3:0]    idx_num,
  output logic [3:0]    base_num,
  output logic          is_store,
  output logic [AW-1:0] ea
);
  rx_fields_t f;
  logic [AW-1:0] base_term;
  logic [AW-1:0] idx_term;

  always_comb begin
    f         = rx_fields_t'(instr_word);
    src_num   = f.src;
    idx_num   = f.idx;
    base_num  = f.base;
    is_store  = (f.opc == OPC_STORE_WORD);
    base_term = (f.base == 4'd0) ? '0 : base_val;
    idx_term  = (f.idx  == 4'd0) ? '0 : idx_val;
    ea        = base_term + idx_term + AW'(f.disp);
  end
endmodule

// File: rtl/rxs_fault_check.sv
module rxs_fault_check
  import rxs_pkg::*;
#(
  parameter int unsigned AW              = 32,
  parameter int unsigned MEM_BYTES       = 8192,
  parameter int unsigned KEY_BLOCK_BYTES = 2048
) (
  input  logic                                               clk,
  input  logic                                               rst_n,
  input  logic                                               key_we,
  input  logic [$clog2(MEM_BYTES/KEY_BLOCK_BYTES)-1:0]       key_blk,
  input  logic [3:0]                                         key_wdata,
  input  logic [AW-1:0]                                      ea,
  input  logic [3:0]                                         acc_key,
  output fault_e                                             fault
);
  localparam int unsigned NBLK      = MEM_BYTES / KEY_BLOCK_BYTES;
  localparam int unsigned KEY_IDX_W = $clog2(NBLK);
  localparam int unsigned KEY_SHIFT = $clog2(KEY_BLOCK_BYTES);

  logic [3:0] keys_q [NBLK];
  logic [3:0] keys_d [NBLK];

  always_comb begin
    for (int i = 0; i < NBLK; i++) begin
      keys_d[i] = keys_q[i];
    end
    if (key_we) begin
      keys_d[key_blk] = key_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        keys_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NBLK; i++) begin
        keys_q[i] <= keys_d[i];
      end
    end
  end

  logic                 out_of_range;
  logic                 misaligned;
  logic                 key_bad;
  logic [KEY_IDX_W-1:0] blk;

  always_comb begin
    out_of_range = (ea >= AW'(MEM_BYTES));
    misaligned   = (ea[1:0] != 2'b00);
    blk          = ea[KEY_SHIFT +: KEY_IDX_W];
    key_bad      = (acc_key != 4'd0) && (keys_q[blk] != acc_key);
    if (out_of_range)    fault = FLT_RANGE;
    else if (misaligned) fault = FLT_ALIGN;
    else if (key_bad)    fault = FLT_PROT;
    else                 fault = FLT_NONE;
  end
endmodule

// File: rtl/rxs_mem_model.sv
module rxs_mem_model #(
  parameter int unsigned MEM_BYTES = 8192
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [$clog2(MEM_BYTES)-1:0] waddr,
  input  logic [31:0]                  wdata,
  input  logic [$clog2(MEM_BYTES)-1:0] raddr,
  output logic [31:0]                  rword,
  output logic [7:0]                   rbyte
);
  localparam int unsigned NWORDS = MEM_BYTES / 4;
  localparam int unsigned AW     = $clog2(MEM_BYTES);

  // Big-endian word lanes: the lowest byte address sits in bits [31:24].
  logic [31:0] words_q [NWORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      words_q[waddr[AW-1:2]] <= wdata;
    end
  end

  always_comb begin
    rword = words_q[raddr[AW-1:2]];
    rbyte = rword[8*(3-int'(raddr[1:0])) +: 8];
  end
endmodule

// File: rtl/rx_store_unit.sv
module rx_store_unit
  import rxs_pkg::*;
#(
  parameter int unsigned MEM_BYTES       = 8192,
  parameter int unsigned KEY_BLOCK_BYTES = 2048,
  parameter int unsigned KEY_IDX_W       = $clog2(MEM_BYTES / KEY_BLOCK_BYTES),
  parameter int unsigned MEM_AW          = $clog2(MEM_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [31:0]          instr_word,
  input  logic [3:0]           access_key,
  input  logic                 gpr_we,
  input  logic [3:0]           gpr_waddr,
  input  logic [31:0]          gpr_wdata,
  input  logic [3:0]           gpr_raddr,
  output logic [31:0]          gpr_rdata,
  input  logic                 key_we,
  input  logic [KEY_IDX_W-1:0] key_blk,
  input  logic [3:0]           key_wdata,
  input  logic                 cc_set_valid,
  input  logic [1:0]           cc_set_value,
  output logic [1:0]           cc_out,
  input  logic [MEM_AW-1:0]    mem_raddr,
  output logic [31:0]          mem_rword,
  output logic [7:0]           mem_rbyte,
  output logic                 done,
  output logic                 wr_strobe,
  output logic [31:0]          wr_addr,
  output logic [31:0]          wr_data,
  output logic [1:0]           fault_code
);
  localparam int unsigned AW = 32;

  logic [3:0]    src_num, idx_num, base_num;
  logic [AW-1:0] src_val, idx_val, base_val, ea;
  logic          is_store;

  rxs_gpr_file #(.NREG(16), .DW(32)) gpr_i (
    .clk(clk), .we(gpr_we), .waddr(gpr_waddr), .wdata(gpr_wdata),
    .ra_src(src_num), .ra_idx(idx_num), .ra_base(base_num), .ra_dbg(gpr_raddr),
    .rd_src(src_val), .rd_idx(idx_val), .rd_base(base_val), .rd_dbg(gpr_rdata)
  );

  rxs_agen #(.AW(AW)) agen_i (
    .instr_word(instr_word), .base_val(base_val), .idx_val(idx_val),
    .src_num(src_num), .idx_num(idx_num), .base_num(base_num),
    .is_store(is_store), .ea(ea)
  );

  // Stage 1: captured address, data and key
  logic          s_vld_q, s_vld_d;
  logic [AW-1:0] s_ea_q, s_ea_d;
  logic [31:0]   s_dat_q, s_dat_d;
  logic [3:0]    s_key_q, s_key_d;
  logic          s_en;

  always_comb begin
    s_vld_d = instr_valid && is_store;
    s_en    = s_vld_d;
    s_ea_d  = ea;
    s_dat_d = src_val;
    s_key_d = access_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld_q <= 1'b0;
      s_ea_q  <= '0;
      s_dat_q <= '0;
      s_key_q <= '0;
    end else begin
      s_vld_q <= s_vld_d;
      if (s_en) begin
        s_ea_q  <= s_ea_d;
        s_dat_q <= s_dat_d;
        s_key_q <= s_key_d;
      end
    end
  end

  fault_e chk_fault;

  rxs_fault_check #(
    .AW(AW), .MEM_BYTES(MEM_BYTES), .KEY_BLOCK_BYTES(KEY_BLOCK_BYTES)
  ) fchk_i (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_blk(key_blk),
    .key_wdata(key_wdata), .ea(s_ea_q), .acc_key(s_key_q), .fault(chk_fault)
  );

  logic mem_we;
  assign mem_we = s_vld_q && (chk_fault == FLT_NONE);

  rxs_mem_model #(.MEM_BYTES(MEM_BYTES)) mem_i (
    .clk(clk), .we(mem_we), .waddr(s_ea_q[MEM_AW-1:0]), .wdata(s_dat_q),
    .raddr(mem_raddr), .rword(mem_rword), .rbyte(mem_rbyte)
  );

  // Stage 2: outcome registers
  logic        done_q, done_d;
  logic        wr_q, wr_d;
  logic [1:0]  flt_q, flt_d;
  logic [31:0] addr_q, addr_d, data_q, data_d;

  always_comb begin
    done_d = s_vld_q;
    wr_d   = mem_we;
    flt_d  = s_vld_q ? chk_fault : FLT_NONE;
    addr_d = mem_we ? s_ea_q : addr_q;
    data_d = mem_we ? s_dat_q : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      flt_q  <= FLT_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      done_q <= done_d;
      wr_q   <= wr_d;
      flt_q  <= flt_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  // Condition code: only the load port touches it
  logic [1:0] cc_q, cc_d;
  always_comb cc_d = cc_set_valid ? cc_set_value : cc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= 2'b00;
    else        cc_q <= cc_d;
  end

  assign done       = done_q;
  assign wr_strobe  = wr_q;
  assign wr_addr    = addr_q;
  assign wr_data    = data_q;
  assign fault_code = flt_q;
  assign cc_out     = cc_q;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int unsigned MEM_BYTES = 8192
) (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [7:0]  instr_opc,
  input logic        cc_set_valid,
  input logic [1:0]  cc_out,
  input logic        done,
  input logic        wr_strobe,
  input logic [31:0] wr_addr,
  input logic [1:0]  fault_code
);
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_strobe != (fault_code != 2'd0)));

  assert_outcome_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe || fault_code != 2'd0) |-> done);

  assert_done_from_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(instr_valid && instr_opc == 8'h50, 2));

  assert_write_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_addr[1:0] == 2'b00));

  assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (wr_addr < 32'(MEM_BYTES)));

  assert_cc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cc_set_valid) |-> $stable(cc_out));
endmodule

bind rx_store_unit rxs_checker #(.MEM_BYTES(MEM_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
  .instr_opc(instr_word[31:24]), .cc_set_valid(cc_set_valid), .cc_out(cc_out),
  .done(done), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .fault_code(fault_code)
);

// File: tb/rx_store_unit_tb_top.sv
module rx_store_unit_tb_top;
  localparam int unsigned MEM_BYTES = 8192;
  localparam int unsigned KEY_IDX_W = 2;
  localparam int unsigned MEM_AW    = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                 instr_valid = 1'b0;
  logic [31:0]          instr_word = '0;
  logic [3:0]           access_key = '0;
  logic                 gpr_we = 1'b0;
  logic [3:0]           gpr_waddr = '0;
  logic [31:0]          gpr_wdata = '0;
  logic [3:0]           gpr_raddr = '0;
  logic [31:0]          gpr_rdata;
  logic                 key_we = 1'b0;
  logic [KEY_IDX_W-1:0] key_blk = '0;
  logic [3:0]           key_wdata = '0;
  logic                 cc_set_valid = 1'b0;
  logic [1:0]           cc_set_value = '0;
  logic [1:0]           cc_out;
  logic [MEM_AW-1:0]    mem_raddr = '0;
  logic [31:0]          mem_rword;
  logic [7:0]           mem_rbyte;
  logic                 done, wr_strobe;
  logic [31:0]          wr_addr, wr_data;
  logic [1:0]           fault_code;

  rx_store_unit dut_i (.*);

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent shadow state
  logic [31:0] sh_gpr [16];
  logic [3:0]  sh_key [4];

  typedef struct {
    logic [1:0]  flt;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } exp_t;
  exp_t sb_q [$];

  task automatic set_gpr(input logic [3:0] n, input logic [31:0] v);
    gpr_we = 1'b1; gpr_waddr = n; gpr_wdata = v;
    sh_gpr[n] = v;
    @(negedge clk);
    gpr_we = 1'b0;
  endtask

  task automatic set_key(input logic [KEY_IDX_W-1:0] b, input logic [3:0] k);
    key_we = 1'b1; key_blk = b; key_wdata = k;
    sh_key[b] = k;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  // Driver: computes expected outcome from the requirements and pushes it
  task automatic issue(input logic [7:0] opc, input logic [3:0] src,
                       input logic [3:0] idx, input logic [3:0] base,
                       input logic [11:0] disp, input logic [3:0] akey,
                       input string req);
    exp_t e;
    logic [31:0] ea;
    ea = ((base == 0) ? 32'd0 : sh_gpr[base]) + ((idx == 0) ? 32'd0 : sh_gpr[idx])
         + {20'd0, disp};
    if (ea >= MEM_BYTES)                               e.flt = 2'd1;
    else if (ea[1:0] != 2'b00)                         e.flt = 2'd2;
    else if (akey != 0 && sh_key[ea[12:11]] != akey)   e.flt = 2'd3;
    else                                               e.flt = 2'd0;
    e.addr = ea; e.data = sh_gpr[src]; e.req = req;
    if (opc == 8'h50) sb_q.push_back(e);
    instr_valid = 1'b1; instr_word = {opc, src, idx, base, disp}; access_key = akey;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check("R1", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, "fault_code R9", {30'd0, fault_code}, {30'd0, e.flt});
        check(e.req, "wr_strobe R10", {31'd0, wr_strobe}, {31'd0, e.flt == 2'd0});
        if (e.flt == 2'd0) begin
          check(e.req, "wr_addr R3 R4", wr_addr, e.addr);
          check(e.req, "wr_data R5", wr_data, e.data);
        end
      end
    end else if (rst_n) begin
      if (wr_strobe || fault_code != 0)
        check("R10", "outcome without done", 32'd1, 32'd0);
    end
  end

  task automatic read_word(input logic [31:0] a, input logic [31:0] exp, input string req);
    mem_raddr = a[MEM_AW-1:0];
    #1;
    check(req, "memory word", mem_rword, exp);
  endtask

  task automatic read_byte(input logic [31:0] a, input logic [7:0] exp, input string req);
    mem_raddr = a[MEM_AW-1:0];
    #1;
    check(req, "memory byte", {24'd0, mem_rbyte}, {24'd0, exp});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "reset done", {31'd0, done}, 32'd0);
    check("R10", "reset wr_strobe", {31'd0, wr_strobe}, 32'd0);
    check("R9", "reset fault", {30'd0, fault_code}, 32'd0);
    check("R11", "reset cc", {30'd0, cc_out}, 32'd0);

    set_gpr(0, 32'hDEAD0000);
    set_gpr(1, 32'h11223344);
    set_gpr(2, 32'h00000100);
    set_gpr(3, 32'h00000020);
    set_gpr(4, 32'hFFFFFFF0);
    set_gpr(5, 32'h00000010);
    set_gpr(6, 32'h00002000);
    set_gpr(8, 32'h00000800);
    set_gpr(9, 32'hCAFEF00D);
    set_gpr(10, 32'hA5A50001);
    set_gpr(11, 32'h00000001);
    set_key(0, 4'd2); set_key(1, 4'd5); set_key(2, 4'd2); set_key(3, 4'd7);
    cc_set_valid = 1'b1; cc_set_value = 2'b10;
    @(negedge clk);
    cc_set_valid = 1'b0;

    // Back-to-back stores
    issue(8'h50, 1, 0, 2, 12'h000, 2, "R3 base only, index 0 ignored");
    issue(8'h50, 1, 0, 2, 12'h004, 2, "R2 displacement field");
    issue(8'h50, 9, 0, 2, 12'h002, 2, "R6 misaligned");
    issue(8'h50, 1, 3, 2, 12'h008, 2, "R4 index added");
    issue(8'h50, 1, 0, 0, 12'h040, 2, "R3 base 0 ignored");
    issue(8'h50, 1, 5, 4, 12'h010, 2, "R4 wrap modulo 2^32");
    issue(8'h50, 1, 0, 6, 12'h000, 2, "R7 out of range");
    issue(8'h50, 1, 0, 6, 12'h001, 2, "R9 range over align");
    issue(8'h50, 10, 0, 8, 12'h000, 0, "R8 key 0 always writes");
    issue(8'h50, 9, 0, 8, 12'h000, 2, "R8 key mismatch");
    issue(8'h50, 9, 0, 8, 12'h001, 2, "R9 align over protect");
    issue(8'h50, 10, 0, 8, 12'h004, 5, "R8 matching key");
    issue(8'h50, 1, 0, 11, 12'hFFF, 2, "R3 max displacement");
    issue(8'h58, 9, 0, 0, 12'h040, 2, "R1 other opcode");
    repeat (4) @(negedge clk);

    check("R10", "scoreboard drained", sb_q.size(), 32'd0);
    read_word(32'h100, 32'h11223344, "R6 misaligned store left word unchanged");
    read_byte(32'h100, 8'h11, "R5 big-endian first byte");
    read_byte(32'h103, 8'h44, "R5 big-endian last byte");
    read_word(32'h104, 32'h11223344, "R2");
    read_word(32'h128, 32'h11223344, "R4");
    read_word(32'h040, 32'h11223344, "R1 ignored opcode no write");
    read_word(32'h010, 32'h11223344, "R4 wrap");
    read_word(32'h800, 32'hA5A50001, "R8 protect fault no write");
    read_word(32'h804, 32'hA5A50001, "R8");
    read_word(32'h1000, 32'h11223344, "R3");
    gpr_raddr = 4'd1;
    #1;
    check("R5", "source register unchanged", gpr_rdata, 32'h11223344);
    check("R11", "cc unchanged by stores", {30'd0, cc_out}, 32'd2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule